// File: doc/BRIEF.md
# Subclock Watch Interval Timer

A free-running counter runs on a slow subclock and serves as a periodic interval source. Whenever the counter bit picked by a 3-bit interval select field rises, a flag is raised in the bus clock domain. If the interrupt enable is set, an interrupt request follows. The period is measured from the last point at which the counter was cleared.

The counter is cleared in three ways: by power-on reset, while a stop-mode input is high, or when software writes zero to a clear bit in the control register. A second pair of counter taps is brought out as a clock for a companion watchdog, and a register bit chooses between those two taps.

Software reaches the block through a single 8-bit control register. Writes take one bus cycle, and reads are combinational.

Top module: `subclk_interval_timer`

## Requirements
- R1: The counter advances by one on each rising subclock edge and holds its value while the subclock is not toggling.
- R2: After power-on reset the register reads 8'h08, irq is 0, wdt_clk is 0, sub_sel is 0 and the counter is zero.
- R3: While stop_mode is high the counter is held at zero. The flag and the register fields are not touched.
- R4: Writing 0 to bit 3 clears the counter to zero. Writing 1 to bit 3 leaves the counter running. Bit 3 always reads back as 1.
- R5: The flag (bit 4) becomes 1 when counter bit TAP_BASE+isel goes from 0 to 1, as sampled at subclock edges, where isel is bits 2..0. After a clear this happens 2^(TAP_BASE+isel) subclock edges later.
- R6: irq is 1 exactly when the flag (bit 4) and the interrupt enable (bit 5) are both 1.
- R7: Writing 0 to bit 4 clears the flag. Writing 1 to bit 4 leaves the flag unchanged.
- R8: When a hardware flag set and a software flag clear land in the same bus cycle, the flag ends up 1.
- R9: wdt_clk equals counter bit WDT_HI when bit 7 is 0, and counter bit WDT_LO when bit 7 is 1.
- R10: Bits 7, 6, 5 and 2..0 read back the last value written, and the sub_sel output follows bit 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sclk | input | 1 | Low-speed subclock driving the counter |
| stop_mode | input | 1 | High while the device is in stop mode; clears the counter |
| wr_en | input | 1 | Register write strobe, one bus cycle |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| irq | output | 1 | Interval interrupt request |
| wdt_clk | output | 1 | Counter tap supplied to the watchdog |
| sub_sel | output | 1 | Subclock select bit as held in the register |

## Verification
The bench builds the block with CNT_W=12, TAP_BASE=4, WDT_HI=11 and WDT_LO=9. With these values the shortest interval is 16 subclock edges and the longest is 2048. Every one of the eight interval codes, and both watchdog taps, can therefore be run to and past its first rising edge in a few thousand subclock edges. The bench drives the subclock itself with a fixed phase against the bus clock. This lets it place a hardware flag set in the same bus cycle as a software clear.

// File: rtl/sit_pkg.sv
package sit_pkg;
  localparam int REG_W    = 8;
  localparam int ISEL_W   = 3;
  localparam int B_WDCS   = 7;
  localparam int B_SUBSEL = 6;
  localparam int B_IE     = 5;
  localparam int B_OVF    = 4;
  localparam int B_CLR    = 3;

  typedef struct packed {
    logic              wdcs;
    logic              sub_sel;
    logic              ie;
    logic              ovf;
    logic [ISEL_W-1:0] isel;
  } ctrl_t;

  // counter bit that sets the flag for a given interval code
  function automatic int unsigned tap_index(input logic [ISEL_W-1:0] isel,
                                            input int unsigned base);
    return base + int'(isel);
  endfunction

  // readback image; the clear bit always reads as one
  function automatic logic [REG_W-1:0] pack_reg(input ctrl_t c);
    return {c.wdcs, c.sub_sel, c.ie, c.ovf, 1'b1, c.isel};
  endfunction
endpackage

// File: rtl/sit_counter.sv
module sit_counter
  import sit_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int TAP_BASE = 8,
  parameter int WDT_HI   = 15,
  parameter int WDT_LO   = 13
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic [ISEL_W-1:0] isel,
  input  logic              wdcs,
  output logic              evt_tgl,
  output logic              wdt_clk
);
  localparam int TSW = $clog2(CNT_W);

  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic [TSW-1:0]   tap_sel;
  logic             tap_q, new_bit, hit;

  always_comb begin
    tap_sel = TSW'(tap_index(isel, TAP_BASE));
    cnt_nxt = cnt + 1'b1;
    new_bit = cnt_nxt[tap_sel];
    hit     = new_bit & ~tap_q;
  end

  always_comb begin
    assert (int'(tap_sel) < CNT_W) else $error("p_tap_range_r5: tap beyond counter");
  end

  always_ff @(posedge sclk or negedge clr_n) begin
    if (!clr_n) begin
      cnt   <= '0;
      tap_q <= 1'b0;
    end else begin
      cnt   <= cnt_nxt;
      tap_q <= new_bit;
    end
  end

  // event toggle only reset at power-on so no edge is invented by a clear
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)   evt_tgl <= 1'b0;
    else if (hit) evt_tgl <= ~evt_tgl;
  end

  assign wdt_clk = wdcs ? cnt[WDT_LO] : cnt[WDT_HI];
endmodule

// File: rtl/sit_sync.sv
module sit_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= tgl_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign pulse = s2 ^ s3;
endmodule

// File: rtl/sit_ctrl.sv
module sit_ctrl
  import sit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             set_evt,
  output ctrl_t            ctrl,
  output logic             clr_pulse
);
  logic sw_ovf_clr;
  assign sw_ovf_clr = wr_en & ~wr_data[B_OVF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      clr_pulse <= 1'b0;
    end else begin
      clr_pulse <= wr_en & ~wr_data[B_CLR];
      if (wr_en) begin
        ctrl.wdcs    <= wr_data[B_WDCS];
        ctrl.sub_sel <= wr_data[B_SUBSEL];
        ctrl.ie      <= wr_data[B_IE];
        ctrl.isel    <= wr_data[ISEL_W-1:0];
      end
      if (set_evt)         ctrl.ovf <= 1'b1;
      else if (sw_ovf_clr) ctrl.ovf <= 1'b0;
    end
  end

  p_clr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> ctrl.ovf);
  p_flag_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl.ovf) |-> $past(set_evt));
  p_w1_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_OVF] && !set_evt) |=> $stable(ctrl.ovf));
endmodule

// File: rtl/subclk_interval_timer.sv
module subclk_interval_timer
  import sit_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int TAP_BASE = 8,
  parameter int WDT_HI   = 15,
  parameter int WDT_LO   = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       stop_mode,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       wdt_clk,
  output logic       sub_sel
);
  ctrl_t ctrl;
  logic  clr_pulse, cnt_clr_n, evt_tgl, set_evt;

  assign cnt_clr_n = rst_n & ~stop_mode & ~clr_pulse;

  sit_counter #(
    .CNT_W(CNT_W), .TAP_BASE(TAP_BASE), .WDT_HI(WDT_HI), .WDT_LO(WDT_LO)
  ) u_cnt (
    .sclk(sclk), .rst_n(rst_n), .clr_n(cnt_clr_n), .isel(ctrl.isel),
    .wdcs(ctrl.wdcs), .evt_tgl(evt_tgl), .wdt_clk(wdt_clk)
  );

  sit_sync u_sync (.clk(clk), .rst_n(rst_n), .tgl_in(evt_tgl), .pulse(set_evt));

  sit_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .set_evt(set_evt), .ctrl(ctrl), .clr_pulse(clr_pulse)
  );

  assign rd_data = pack_reg(ctrl);
  assign irq     = ctrl.ovf & ctrl.ie;
  assign sub_sel = ctrl.sub_sel;

  p_irq_on_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && ctrl.ie && !(wr_en && !wr_data[B_IE])) |=> irq);
endmodule

// File: tb/subclk_interval_timer_test.sv
module subclk_interval_timer_test;
  localparam int CW = 12;
  localparam int TB = 4;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, stop_mode = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic irq, wdt_clk, sub_sel;

  int vectors = 0, fails = 0;
  bit done = 1'b0;

  logic m_wdcs = 0, m_sub = 0, m_ie = 0, m_ovf = 0, m_prev = 0;
  logic [2:0] m_isel = 0;
  logic [CW-1:0] m_cnt = 0;

  always #5 clk = ~clk;

  subclk_interval_timer #(.CNT_W(CW), .TAP_BASE(TB), .WDT_HI(11), .WDT_LO(9)) uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .stop_mode(stop_mode), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .wdt_clk(wdt_clk), .sub_sel(sub_sel)
  );

  function automatic logic [7:0] exp_reg();
    logic [7:0] r;
    r[7] = m_wdcs; r[6] = m_sub; r[5] = m_ie; r[4] = m_ovf; r[3] = 1'b1; r[2:0] = m_isel;
    return r;
  endfunction

  function automatic logic exp_wdt();
    return m_wdcs ? m_cnt[9] : m_cnt[11];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, rd_data, exp_reg());
    chk("R6 irq", {7'd0, irq}, {7'd0, m_ovf & m_ie});
    chk("R9 wdt_clk", {7'd0, wdt_clk}, {7'd0, exp_wdt()});
    chk("R10 sub_sel", {7'd0, sub_sel}, {7'd0, m_sub});
  endtask

  // model of one subclock edge (R1, R5)
  task automatic model_tick();
    logic [CW-1:0] n;
    logic b;
    n = m_cnt + 1'b1;
    b = n[TB + int'(m_isel)];
    if (b && !m_prev) m_ovf = 1'b1;
    m_prev = b;
    m_cnt  = n;
  endtask

  task automatic tick();
    @(negedge clk) sclk = 1'b1;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    model_tick();
  endtask

  task automatic bus_write(input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
    @(negedge clk);
    m_wdcs = d[7]; m_sub = d[6]; m_ie = d[5]; m_isel = d[2:0];
    if (!d[3]) begin m_cnt = '0; m_prev = 1'b0; end
    if (!d[4]) m_ovf = 1'b0;
  endtask

  task automatic stop_pulse();
    @(negedge clk) stop_mode = 1'b1;
    @(negedge clk) stop_mode = 1'b0;
    @(negedge clk);
    m_cnt = '0; m_prev = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd17));
    repeat (4) @(negedge clk);
    check_all("R2 reset");
    chk("R2 rd_data", rd_data, 8'h08);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1/R5: shortest interval from reset
    for (int i = 0; i < 15; i++) begin tick(); check_all("R1 count"); end
    chk("R5 flag not yet", {7'd0, rd_data[4]}, 8'd0);
    tick();
    chk("R5 flag at 16", {7'd0, rd_data[4]}, 8'd1);
    repeat (20) @(negedge clk);
    check_all("R1 hold");

    // R7: write one keeps, write zero clears
    bus_write(8'h18); check_all("R7 w1 keep");
    bus_write(8'h28); check_all("R7 w0 clear");
    for (int i = 0; i < 40; i++) begin tick(); check_all("R6 irq enabled"); end

    // R4: clear by writing zero; interval measured from clear
    for (int i = 0; i < 5; i++) tick();
    bus_write(8'h21); check_all("R4 clear");
    for (int i = 0; i < 32; i++) begin tick(); check_all("R4 after clear"); end
    bus_write(8'h29); check_all("R4 write one no clear");
    for (int i = 0; i < 3; i++) begin tick(); check_all("R4 still counting"); end

    // R3: stop mode clears counter only
    stop_pulse(); check_all("R3 stop");
    for (int i = 0; i < 40; i++) begin tick(); check_all("R3 after stop"); end

    // R9/R5: longest interval, alternate watchdog tap
    bus_write(8'hC7);
    for (int i = 0; i < 2050; i++) begin tick(); check_all("R5 isel7"); end
    bus_write(8'h47); check_all("R9 high tap");

    // R8: hardware set and software clear in one cycle
    bus_write(8'h00);
    for (int i = 0; i < 15; i++) tick();
    check_all("R8 prep");
    @(negedge clk) sclk = 1'b1;
    @(negedge clk);
    @(negedge clk) begin wr_en = 1'b1; wr_data = 8'h08; end
    @(negedge clk) begin wr_en = 1'b0; sclk = 1'b0; end
    repeat (2) @(negedge clk);
    model_tick();
    m_ovf = 1'b1;
    chk("R8 set wins", {7'd0, rd_data[4]}, 8'd1);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      int unsigned r;
      logic [7:0] d;
      r = $urandom % 16;
      if (r < 11) tick();
      else if (r < 14) begin
        d = 8'($urandom);
        d[3] = (($urandom % 8) != 0);
        bus_write(d);
      end else if (r == 14) stop_pulse();
      else repeat (3) @(negedge clk);
      check_all("R10 random");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule